// File: doc/BRIEF.md
# Temperature Histogram Bin Accumulator

This block builds a temperature histogram over the course of a logging mission. Each time a new temperature sample is strobed in, the block works out which 2 degree wide bin the sample belongs to. It then adds one to that bin's counter. The counters live in an on-chip register array. The internal control logic is the only thing that changes them. A host reads the array one byte at a time through a read-only port.

Temperature codes are two's complement numbers in half-degree steps, so four neighbouring codes share a bin. Codes below the lowest bin are counted in the lowest bin, and codes above the top bin are counted in the top bin. A counter stops at its maximum value and does not wrap.

A one-cycle mission-clear pulse starts a sweep that zeroes one bin per cycle. Samples are refused until the sweep ends, so a new mission starts from an empty histogram.

Top module: `thb_top`

## Requirements
- R1: After reset every bin counter reads zero.
- R2: With the default lowest code of -80 (9-bit two's complement, 0.5 degree units), an accepted sample with code c in range goes to bin (c + 80) >> 2, so codes -80..-77 land in bin 0 and code 171 lands in bin 62.
- R3: Codes below -80 are counted in bin 0, and codes above 171 are counted in bin 62.
- R4: Every accepted sample adds exactly one to its bin, including samples that arrive on back-to-back cycles into the same bin. The count can be read from the third clock edge after the sample's edge onward.
- R5: A counter that holds 0xFFFF stays at 0xFFFF when further samples hit its bin.
- R6: A one-cycle clr_req pulse clears all 63 counters, one per cycle, on the 63 clock edges that follow the pulse.
- R7: A sample presented on the same edge as clr_req, or on any of the 63 following edges, is discarded. The first sample accepted after a clear is on the 64th edge after the pulse.
- R8: Byte address 2b returns the low byte of bin b and address 2b+1 returns its high byte. rd_data shows the byte for the address present at the previous clock edge.
- R9: Byte addresses 126 and 127 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | New temperature sample strobe |
| smp_code | input | 9 | Signed temperature code, 0.5 degree per step |
| clr_req | input | 1 | Mission-clear pulse |
| rd_addr | input | 7 | Host byte address into the bin storage |
| rd_data | output | 8 | Registered byte read from the bin storage |

## Verification
The hardest state to reach from the ports is a saturated counter, because it takes 65,535 samples into one bin before the limit matters. The stimulus streams 65,537 back-to-back samples at a single code and then reads that bin and one of its neighbours. The clear window is also hard to observe. Valid samples spread over many bins are driven on every one of the 63 sweep edges, so if the window is one cycle too short or too long, a nonzero bin shows up on the following read-out.

// File: rtl/thb_pkg.sv
package thb_pkg;
  parameter int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  // saturating increment used by every bin
  function automatic cnt_t sat_inc(cnt_t v);
    if (v == '1) return v;
    return v + cnt_t'(1);
  endfunction
endpackage

// File: rtl/thb_bin_map.sv
module thb_bin_map #(
  parameter int CODE_W   = 9,
  parameter int LOW_CODE = -80,
  parameter int SHIFT    = 2,
  parameter int NUM_BINS = 63,
  parameter int IDX_W    = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [IDX_W-1:0]  idx
);
  localparam logic signed [CODE_W:0] LOW_EXT = (CODE_W+1)'(LOW_CODE);
  localparam logic signed [CODE_W:0] TOP_BIN = (CODE_W+1)'(NUM_BINS-1);

  logic signed [CODE_W:0] code_ext;
  logic signed [CODE_W:0] diff;
  logic signed [CODE_W:0] shr;

  always_comb begin
    code_ext = {code[CODE_W-1], code};
    diff     = code_ext - LOW_EXT;
    shr      = diff >>> SHIFT;
    if (diff[CODE_W])
      idx = '0;
    else if (shr > TOP_BIN)
      idx = IDX_W'(NUM_BINS-1);
    else
      idx = shr[IDX_W-1:0];
  end
endmodule

// File: rtl/thb_clear_seq.sv
module thb_clear_seq #(
  parameter int NUM_BINS = 63,
  parameter int IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output logic [IDX_W-1:0] ptr
);
  logic             act_d;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    act_d = active;
    ptr_d = ptr;
    if (start) begin
      act_d = 1'b1;
      ptr_d = '0;
    end else if (active) begin
      if (ptr == IDX_W'(NUM_BINS-1))
        act_d = 1'b0;
      else
        ptr_d = ptr + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ptr    <= '0;
    end else begin
      active <= act_d;
      ptr    <= ptr_d;
    end
  end
endmodule

// File: rtl/thb_bin_store.sv
module thb_bin_store
  import thb_pkg::*;
#(
  parameter int NUM_BINS = 63,
  parameter int IDX_W    = 6,
  parameter int ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic [IDX_W-1:0]  inc_idx,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int NUM_BYTES = NUM_BINS * 2;

  cnt_t bins_q [NUM_BINS];
  cnt_t bins_d [NUM_BINS];
  logic [NUM_BINS-1:0] bin_we;

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
    always_comb begin
      bin_we[g] = 1'b0;
      bins_d[g] = bins_q[g];
      if (clr_en && clr_idx == IDX_W'(g)) begin
        bin_we[g] = 1'b1;
        bins_d[g] = '0;
      end else if (inc_en && inc_idx == IDX_W'(g)) begin
        bin_we[g] = 1'b1;
        bins_d[g] = sat_inc(bins_q[g]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bins_q[g] <= '0;
      else if (bin_we[g])
        bins_q[g] <= bins_d[g];
    end
  end

  logic [IDX_W-1:0] rd_bin;
  logic             rd_hit;
  cnt_t             rd_word;
  logic [7:0]       rd_byte;

  always_comb begin
    rd_bin  = IDX_W'(rd_addr >> 1);
    rd_hit  = (int'(rd_addr) < NUM_BYTES);
    rd_word = rd_hit ? bins_q[rd_bin] : '0;
    rd_byte = rd_addr[0] ? rd_word[15:8] : rd_word[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else
      rd_data <= rd_byte;
  end
endmodule

// File: rtl/thb_top.sv
module thb_top #(
  parameter int CODE_W   = 9,
  parameter int LOW_CODE = -80,
  parameter int SHIFT    = 2,
  parameter int NUM_BINS = 63,
  parameter int IDX_W    = $clog2(NUM_BINS),
  parameter int ADDR_W   = $clog2(NUM_BINS * 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              clr_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic             clearing;
  logic [IDX_W-1:0] clr_ptr;
  logic [IDX_W-1:0] map_idx;
  logic             accept;
  logic             s1_vld, s1_vld_d;
  logic [IDX_W-1:0] s1_idx, s1_idx_d;

  thb_bin_map #(
    .CODE_W(CODE_W), .LOW_CODE(LOW_CODE), .SHIFT(SHIFT),
    .NUM_BINS(NUM_BINS), .IDX_W(IDX_W)
  ) u_map (
    .code(smp_code),
    .idx (map_idx)
  );

  thb_clear_seq #(.NUM_BINS(NUM_BINS), .IDX_W(IDX_W)) u_clr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (clr_req),
    .active(clearing),
    .ptr   (clr_ptr)
  );

  always_comb begin
    accept   = smp_valid && !clr_req && !clearing;
    s1_vld_d = accept;
    s1_idx_d = accept ? map_idx : s1_idx;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld <= 1'b0;
      s1_idx <= '0;
    end else begin
      s1_vld <= s1_vld_d;
      s1_idx <= s1_idx_d;
    end
  end

  thb_bin_store #(
    .NUM_BINS(NUM_BINS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .inc_en (s1_vld),
    .inc_idx(s1_idx),
    .clr_en (clearing),
    .clr_idx(clr_ptr),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/thb_checker.sv
module thb_checker #(
  parameter int CODE_W   = 9,
  parameter int LOW_CODE = -80,
  parameter int SHIFT    = 2,
  parameter int NUM_BINS = 63,
  parameter int IDX_W    = 6,
  parameter int ADDR_W   = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_valid,
  input logic signed [CODE_W-1:0] smp_code,
  input logic                     clr_req,
  input logic                     clearing,
  input logic                     s1_vld,
  input logic [IDX_W-1:0]         s1_idx,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [7:0]               rd_data
);
  localparam int HIGH_EDGE = LOW_CODE + (NUM_BINS << SHIFT);

  int unsigned sweep_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sweep_cnt <= 0;
    else if (clr_req)  sweep_cnt <= 0;
    else if (clearing) sweep_cnt <= sweep_cnt + 1;
  end

  // R2: the bin index never leaves the table
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (int'(s1_idx) < NUM_BINS));

  // R3: low-side clamp
  a_r3_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !clr_req && !clearing && int'(smp_code) < LOW_CODE)
      |=> (s1_vld && s1_idx == '0));

  // R3: high-side clamp
  a_r3_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !clr_req && !clearing && int'(smp_code) >= HIGH_EDGE)
      |=> (s1_vld && int'(s1_idx) == NUM_BINS-1));

  // R6: the sweep lasts exactly one cycle per bin
  a_r6_sweep_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!clearing && $past(clearing) && !$past(clr_req)) |-> (sweep_cnt == NUM_BINS));

  // R7: no sample enters the pipeline around a clear
  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req || clearing) |=> !s1_vld);

  // R9: addresses past the table read zero
  a_r9_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= 2*NUM_BINS) |=> (rd_data == 8'h00));
endmodule

bind thb_top thb_checker #(
  .CODE_W(CODE_W), .LOW_CODE(LOW_CODE), .SHIFT(SHIFT),
  .NUM_BINS(NUM_BINS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .smp_valid(smp_valid),
  .smp_code (smp_code),
  .clr_req  (clr_req),
  .clearing (clearing),
  .s1_vld   (s1_vld),
  .s1_idx   (s1_idx),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data)
);

// File: tb/thb_top_test.sv
`timescale 1ns/1ps
module thb_top_test;
  localparam int NB  = 63;
  localparam int LOW = -80;

  logic       clk;
  logic       rst_n;
  logic       smp_valid;
  logic [8:0] smp_code;
  logic       clr_req;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;

  int n_run;
  int n_fail;
  bit done;
  int ref_cnt [NB];

  thb_top uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .clr_req(clr_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int bin_of(int c);
    int b;
    if (c < LOW) return 0;
    b = (c - LOW) / 4;
    if (b > NB-1) b = NB-1;
    return b;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(int c);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_code  = 9'(c);
    if (ref_cnt[bin_of(c)] < 65535) ref_cnt[bin_of(c)]++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic read_byte(int a, output int v);
    @(negedge clk);
    smp_valid = 1'b0;
    rd_addr   = 7'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic read_bin(int b, output int v);
    int lo, hi;
    read_byte(2*b, lo);
    read_byte(2*b+1, hi);
    v = lo + 256*hi;
  endtask

  task automatic check_all(string req);
    int v;
    idle(3);
    for (int b = 0; b < NB; b++) begin
      read_bin(b, v);
      check(req, v, ref_cnt[b]);
    end
  endtask

  initial begin
    done = 1'b0;
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    n_run = 0;
    n_fail = 0;
    void'($urandom(32'h5eed_0421));
    for (int b = 0; b < NB; b++) ref_cnt[b] = 0;
    rst_n = 1'b0; smp_valid = 1'b0; smp_code = '0; clr_req = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: all bins empty after reset
    check_all("R1");
    // R9: holes past the table
    read_byte(126, v); check("R9", v, 0);
    read_byte(127, v); check("R9", v, 0);

    // R2: four codes per bin, edges of the range
    for (int c = -80; c <= -76; c++) push(c);
    push(171);
    // R3: clamping beyond both ends
    push(-256); push(-81); push(172); push(255);
    idle(3);
    read_bin(0, v);  check("R2", v, 6);
    read_bin(1, v);  check("R2", v, 1);
    read_bin(62, v); check("R3", v, 3);

    // R4: back-to-back samples into one bin
    for (int i = 0; i < 5; i++) push(0);
    idle(3);
    read_bin(20, v); check("R4", v, 5);

    // R8: byte order, 300 = 0x012C
    for (int i = 0; i < 300; i++) push(41);
    idle(3);
    read_byte(60, v); check("R8", v, 8'h2C);
    read_byte(61, v); check("R8", v, 8'h01);

    // R2/R4: constrained random stream with gaps
    for (int i = 0; i < 3000; i++) begin
      int c;
      if ($urandom_range(0, 3) == 0) idle(1);
      if ($urandom_range(0, 9) < 7) c = int'($urandom_range(0, 270)) - 90;
      else                          c = int'($urandom_range(0, 511)) - 256;
      push(c);
    end
    check_all("R4");

    // R6/R7: clear with samples on every edge of the sweep
    @(negedge clk);
    clr_req = 1'b1; smp_valid = 1'b1; smp_code = 9'(0);
    @(negedge clk);
    clr_req = 1'b0; smp_code = 9'(-80);
    for (int k = 1; k < 63; k++) begin
      @(negedge clk);
      smp_code = 9'(4*k - 80);
    end
    for (int b = 0; b < NB; b++) ref_cnt[b] = 0;
    push(-60);  // 64th edge: first accepted, bin 5
    check_all("R6");
    read_bin(5, v);  check("R7", v, 1);
    read_bin(62, v); check("R7", v, 0);

    // R5: saturation
    for (int i = 0; i < 65537; i++) push(100);
    idle(3);
    read_bin(45, v); check("R5", v, 65535);
    read_bin(44, v); check("R5", v, 0);
    read_byte(90, v); check("R5", v, 255);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule